// File: doc/BRIEF.md
# Hardware Performance Monitor

This block sits next to an application design on the same chip. It records how that design behaves at runtime, and it never stalls the design. A bank of saturating profile counters counts cycles on triggers. Each counter has its own trigger, and the host configures each trigger separately. A trigger can fire when a chosen monitored input matches a programmed value, when that input differs from the value, or on a periodic sample strobe. A common use is profiling a state machine: feed its state code in as a monitored input and give each state one counter in match mode. Each counter then holds the number of cycles spent in that state.

A free-running cycle counter supplies timestamps. Whenever the trace event input is high, a record is pushed into a circular trace buffer. Each record holds the current timestamp and a data word. The host polls the counters through an atomic read port and drains the trace buffer continuously. When the buffer is full, new records are dropped, and a sticky overflow flag and a saturating drop count show that records were lost. A global enable starts and pauses all measurement. A synchronous clear resets every counter, the timestamp and the sample divider together.

Top module: `perfmon_top`

## Requirements
- R1: After reset, every profile counter and the timestamp are zero. The trace buffer is empty, the overflow flag and the drop count are zero, and both read-valid outputs are low.
- R2: A counter configured with mode code 1 (match) increments on each enabled cycle in which its selected monitored input equals its programmed value.
- R3: A counter configured with mode code 2 (mismatch) increments on each enabled cycle in which its selected monitored input differs from its programmed value. A counter with mode code 0 never increments.
- R4: A counter configured with mode code 3 (sample) increments once per `sample_period` enabled cycles, counting from the last clear. Over N enabled cycles it reaches floor(N/period). A period of 0 behaves as a period of 1.
- R5: Each counter counts only its own trigger, independently of the others. A counter stops at 2^CTR_W-1 and does not wrap.
- R6: While `mon_en` is low, the counters, the timestamp and the sample divider hold their values, and `trace_evt` pushes no record.
- R7: A `clr_all` pulse sets every counter, the timestamp and the sample divider to zero on the next edge. The clear takes priority over an increment in the same cycle.
- R8: A `ctr_rd_req` latches the selected counter's value, as it stood before that edge, into a holding register. That register is presented on the next cycle with `ctr_rd_valid` high. It keeps its value until the next request.
- R9: Each enabled cycle with `trace_evt` high stores a record {timestamp, `trace_data`}. The timestamp equals the number of enabled cycles since the last clear or reset, counted before the current cycle. Records come out in the order they were stored.
- R10: A `trace_pop` on a non-empty buffer presents the oldest record on the next cycle with `trace_rd_valid` high. A pop on an empty buffer leaves `trace_rd_valid` low. `trace_level` always gives the number of stored records.
- R11: A push into a full buffer is dropped. It sets `trace_ovf`, which stays set, and increments `trace_drops`, which saturates at 2^DROP_W-1. An `ovf_clr` pulse clears both, but a drop in the same cycle takes priority.
- R12: Tracing can run indefinitely. After the buffer is drained, new records are accepted and read back correctly across the wrap of the read and write pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Global measurement enable |
| clr_all | input | 1 | Synchronous clear of counters, timestamp and sample divider |
| mon_sig | input | NUM_SRC*SIG_W | Monitored inputs, one SIG_W field per source |
| sample_period | input | PERIOD_W | Period of the sample strobe in enabled cycles |
| cfg_we | input | 1 | Write trigger configuration |
| cfg_idx | input | CIDX_W | Counter whose trigger is written |
| cfg_mode | input | 2 | Trigger mode: 0 off, 1 match, 2 mismatch, 3 sample |
| cfg_src | input | SRC_W | Monitored source selected by the trigger |
| cfg_val | input | SIG_W | Compare value |
| trace_evt | input | 1 | Trace event strobe |
| trace_data | input | TD_W | Data word stored with the trace record |
| ctr_rd_req | input | 1 | Counter read request |
| ctr_rd_idx | input | CIDX_W | Counter to read |
| ctr_rd_valid | output | 1 | Holding register was loaded by the previous request |
| ctr_rd_data | output | CTR_W | Counter holding register |
| trace_pop | input | 1 | Remove the oldest trace record |
| ovf_clr | input | 1 | Clear the overflow flag and the drop count |
| trace_rd_valid | output | 1 | Popped record is valid |
| trace_rd_ts | output | TS_W | Timestamp of the popped record |
| trace_rd_data | output | TD_W | Data of the popped record |
| trace_level | output | LVL_W | Records held in the trace buffer |
| trace_ovf | output | 1 | Sticky overflow flag |
| trace_drops | output | DROP_W | Saturating count of dropped records |

## Verification
The match and mismatch triggers are swept against every compare value. The monitored input steps through all sixteen codes, and each code is held for a different number of cycles, so every code gives a different count. A wrong comparison or a wrong source therefore shows up as a wrong number rather than a matching one. The sample trigger is run for a fixed number of cycles at periods 0 to 5, which tells apart an off-by-one divider and the zero-period case. The trace buffer is filled past capacity and drained in order, then refilled across the pointer wrap. Separate cases run until the drop count saturates, freeze measurement with the enable low, and give a clear priority over an increment in the same cycle.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF    = 2'd0,
    TRIG_EQ     = 2'd1,
    TRIG_NE     = 2'd2,
    TRIG_SAMPLE = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/perfmon_sampler.sv
module perfmon_sampler #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                clr,
  input  logic [PERIOD_W-1:0] period,
  output logic                strobe
);
  logic [PERIOD_W-1:0] div_q;
  logic [PERIOD_W-1:0] last;

  // A period of zero is treated as one.
  assign last   = (period == '0) ? '0 : period - 1'b1;
  assign strobe = en && (div_q >= last);

  always_ff @(posedge clk) begin
    if (rst || clr)
      div_q <= '0;
    else if (en)
      div_q <= strobe ? '0 : div_q + 1'b1;
  end

  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(div_q)) else $error("divider moved while disabled"); // R6
endmodule

// File: rtl/perfmon_trigger.sv
module perfmon_trigger
  import perfmon_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SIG_W   = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_mode,
  input  logic [SRC_W-1:0]         cfg_src,
  input  logic [SIG_W-1:0]         cfg_val,
  input  logic [NUM_SRC*SIG_W-1:0] mon_sig,
  input  logic                     strobe,
  output logic                     hit
);
  trig_mode_e       mode_q;
  logic [SRC_W-1:0] src_q;
  logic [SIG_W-1:0] val_q;
  logic [SIG_W-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TRIG_OFF;
      src_q  <= '0;
      val_q  <= '0;
    end else if (cfg_we) begin
      mode_q <= trig_mode_e'(cfg_mode);
      src_q  <= cfg_src;
      val_q  <= cfg_val;
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_q == SRC_W'(i)) sel = mon_sig[i*SIG_W +: SIG_W];
  end

  always_comb begin
    case (mode_q)
      TRIG_EQ:     hit = (sel == val_q);
      TRIG_NE:     hit = (sel != val_q);
      TRIG_SAMPLE: hit = strobe;
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int CTR_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             hit,
  output logic [CTR_W-1:0] cnt
);
  localparam logic [CTR_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en && hit && cnt != MAXV)
      cnt <= cnt + 1'b1;
  end

  AST_CTR_SAT: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXV && !clr) |=> (cnt == MAXV)) else $error("counter wrapped"); // R5
  AST_CTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt)) else $error("counter moved while disabled"); // R6
  AST_CTR_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)) else $error("counter not cleared"); // R7
endmodule

// File: rtl/perfmon_trace_fifo.sv
module perfmon_trace_fifo #(
  parameter int DEPTH  = 256,
  parameter int REC_W  = 64,
  parameter int DROP_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [REC_W-1:0]  rec,
  input  logic              pop,
  input  logic              ovf_clr,
  output logic              rd_valid,
  output logic [REC_W-1:0]  rd_rec,
  output logic [LVL_W-1:0]  level,
  output logic              ovf,
  output logic [DROP_W-1:0] drops
);
  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             full, empty, do_push, do_pop, drop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_rec   <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_pop;
      if (do_pop) rd_rec <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf   <= 1'b0;
      drops <= '0;
    end else if (drop) begin
      ovf <= 1'b1;
      if (drops != '1) drops <= drops + 1'b1;
    end else if (ovf_clr) begin
      ovf   <= 1'b0;
      drops <= '0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH)) else $error("level beyond depth"); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf) else $error("overflow flag lost"); // R11
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (ovf && drops != '0)) else $error("drop not flagged"); // R11
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (pop && level == '0) |=> !rd_valid) else $error("pop on empty gave data"); // R10
endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
  import perfmon_pkg::*;
#(
  parameter int NUM_CTRS    = 16,
  parameter int CTR_W       = 36,
  parameter int NUM_SRC     = 4,
  parameter int SIG_W       = 8,
  parameter int PERIOD_W    = 16,
  parameter int TS_W        = 32,
  parameter int TD_W        = 32,
  parameter int TRACE_DEPTH = 256,
  parameter int DROP_W      = 16,
  localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CIDX_W     = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1,
  localparam int LVL_W      = $clog2(TRACE_DEPTH) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mon_en,
  input  logic                     clr_all,
  input  logic [NUM_SRC*SIG_W-1:0] mon_sig,
  input  logic [PERIOD_W-1:0]      sample_period,
  input  logic                     cfg_we,
  input  logic [CIDX_W-1:0]        cfg_idx,
  input  logic [1:0]               cfg_mode,
  input  logic [SRC_W-1:0]         cfg_src,
  input  logic [SIG_W-1:0]         cfg_val,
  input  logic                     trace_evt,
  input  logic [TD_W-1:0]          trace_data,
  input  logic                     ctr_rd_req,
  input  logic [CIDX_W-1:0]        ctr_rd_idx,
  output logic                     ctr_rd_valid,
  output logic [CTR_W-1:0]         ctr_rd_data,
  input  logic                     trace_pop,
  input  logic                     ovf_clr,
  output logic                     trace_rd_valid,
  output logic [TS_W-1:0]          trace_rd_ts,
  output logic [TD_W-1:0]          trace_rd_data,
  output logic [LVL_W-1:0]         trace_level,
  output logic                     trace_ovf,
  output logic [DROP_W-1:0]        trace_drops
);
  localparam int REC_W = TS_W + TD_W;

  logic [TS_W-1:0]                 ts_q;
  logic                            strobe;
  logic [NUM_CTRS-1:0][CTR_W-1:0]  cnt;
  logic [CTR_W-1:0]                rd_sel;
  logic [REC_W-1:0]                rd_rec;

  // Free-running timestamp; wraps, unlike the profile counters.
  always_ff @(posedge clk) begin
    if (rst || clr_all)
      ts_q <= '0;
    else if (mon_en)
      ts_q <= ts_q + 1'b1;
  end

  perfmon_sampler #(.PERIOD_W(PERIOD_W)) u_sampler (
    .clk(clk), .rst(rst), .en(mon_en), .clr(clr_all),
    .period(sample_period), .strobe(strobe)
  );

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
    logic hit;
    perfmon_trigger #(.NUM_SRC(NUM_SRC), .SIG_W(SIG_W)) u_trig (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we && (cfg_idx == CIDX_W'(g))),
      .cfg_mode(cfg_mode), .cfg_src(cfg_src), .cfg_val(cfg_val),
      .mon_sig(mon_sig), .strobe(strobe), .hit(hit)
    );
    perfmon_counter #(.CTR_W(CTR_W)) u_cnt (
      .clk(clk), .rst(rst), .en(mon_en), .clr(clr_all),
      .hit(hit), .cnt(cnt[g])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_CTRS; i++)
      if (ctr_rd_idx == CIDX_W'(i)) rd_sel = cnt[i];
  end

  // Whole-width holding register: a read never mixes two counter values.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_rd_data  <= '0;
      ctr_rd_valid <= 1'b0;
    end else begin
      ctr_rd_valid <= ctr_rd_req;
      if (ctr_rd_req) ctr_rd_data <= rd_sel;
    end
  end

  perfmon_trace_fifo #(.DEPTH(TRACE_DEPTH), .REC_W(REC_W), .DROP_W(DROP_W)) u_trace (
    .clk(clk), .rst(rst),
    .push(mon_en && trace_evt), .rec({ts_q, trace_data}),
    .pop(trace_pop), .ovf_clr(ovf_clr),
    .rd_valid(trace_rd_valid), .rd_rec(rd_rec),
    .level(trace_level), .ovf(trace_ovf), .drops(trace_drops)
  );

  assign trace_rd_ts   = rd_rec[REC_W-1 -: TS_W];
  assign trace_rd_data = rd_rec[TD_W-1:0];

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctr_rd_req |=> $stable(ctr_rd_data)) else $error("holding register changed"); // R8
  AST_TS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!mon_en && !clr_all) |=> $stable(ts_q)) else $error("timestamp moved while disabled"); // R6
endmodule

// File: tb/tb_perfmon_top.sv
module tb_perfmon_top;
  localparam int NUM_CTRS = 4, CTR_W = 8, NUM_SRC = 2, SIG_W = 4, PERIOD_W = 4;
  localparam int TS_W = 16, TD_W = 8, DEPTH = 8, DROP_W = 4;

  logic clk = 0, rst = 1;
  logic mon_en = 0, clr_all = 0;
  logic [NUM_SRC*SIG_W-1:0] mon_sig = '0;
  logic [PERIOD_W-1:0] sample_period = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_idx = '0, cfg_mode = '0;
  logic cfg_src = 0;
  logic [SIG_W-1:0] cfg_val = '0;
  logic trace_evt = 0;
  logic [TD_W-1:0] trace_data = '0;
  logic ctr_rd_req = 0;
  logic [1:0] ctr_rd_idx = '0;
  logic ctr_rd_valid;
  logic [CTR_W-1:0] ctr_rd_data;
  logic trace_pop = 0, ovf_clr = 0;
  logic trace_rd_valid;
  logic [TS_W-1:0] trace_rd_ts;
  logic [TD_W-1:0] trace_rd_data;
  logic [3:0] trace_level;
  logic trace_ovf;
  logic [DROP_W-1:0] trace_drops;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  perfmon_top #(.NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .NUM_SRC(NUM_SRC), .SIG_W(SIG_W),
    .PERIOD_W(PERIOD_W), .TS_W(TS_W), .TD_W(TD_W), .TRACE_DEPTH(DEPTH), .DROP_W(DROP_W)) dut (
    .clk(clk), .rst(rst), .mon_en(mon_en), .clr_all(clr_all), .mon_sig(mon_sig),
    .sample_period(sample_period), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode),
    .cfg_src(cfg_src), .cfg_val(cfg_val), .trace_evt(trace_evt), .trace_data(trace_data),
    .ctr_rd_req(ctr_rd_req), .ctr_rd_idx(ctr_rd_idx), .ctr_rd_valid(ctr_rd_valid),
    .ctr_rd_data(ctr_rd_data), .trace_pop(trace_pop), .ovf_clr(ovf_clr),
    .trace_rd_valid(trace_rd_valid), .trace_rd_ts(trace_rd_ts), .trace_rd_data(trace_rd_data),
    .trace_level(trace_level), .trace_ovf(trace_ovf), .trace_drops(trace_drops));

  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int mode, input int src, input int val);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_mode = 2'(mode); cfg_src = 1'(src); cfg_val = 4'(val);
    step(); cfg_we = 0;
  endtask

  task automatic clear();
    clr_all = 1; step(); clr_all = 0;
  endtask

  task automatic read_ctr(input int idx, output longint v);
    ctr_rd_req = 1; ctr_rd_idx = 2'(idx); step(); ctr_rd_req = 0;
    chk("R8 read valid", longint'(ctr_rd_valid), 1);
    v = longint'(ctr_rd_data);
  endtask

  task automatic pop_chk(input string req, input longint ets, input longint edata);
    trace_pop = 1; step(); trace_pop = 0;
    chk(req, longint'(trace_rd_valid), 1);
    chk(req, longint'(trace_rd_ts), ets);
    chk(req, longint'(trace_rd_data), edata);
  endtask

  initial begin : wd
    #790000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    longint v;
    repeat (3) step();
    rst = 0; step();

    // R1: reset state
    chk("R1 level", longint'(trace_level), 0);
    chk("R1 ovf", longint'(trace_ovf), 0);
    chk("R1 drops", longint'(trace_drops), 0);
    chk("R1 trace valid", longint'(trace_rd_valid), 0);
    chk("R1 read valid", longint'(ctr_rd_valid), 0);
    for (int i = 0; i < NUM_CTRS; i++) begin
      read_ctr(i, v); chk("R1 counter", v, 0);
    end

    // R2 R3 R5: sweep every compare value; code v held v+1 cycles
    for (int c = 0; c < 16; c++) begin
      cfg(0, 1, 0, c);
      cfg(1, 2, 0, c);
      cfg(3, 1, 1, c);
      clear();
      for (int s = 0; s < 16; s++)
        for (int r = 0; r <= s; r++) begin
          mon_sig = {4'd0, 4'(s)}; mon_en = 1; step();
        end
      mon_en = 0;
      read_ctr(0, v); chk("R2 match count", v, c + 1);
      read_ctr(1, v); chk("R3 mismatch count", v, 136 - (c + 1));
      read_ctr(3, v); chk("R5 independent source", v, (c == 0) ? 136 : 0);
    end

    // R4: sample trigger, periods 0..5 over 37 enabled cycles; R3 mode off
    cfg(2, 3, 0, 0);
    cfg(1, 0, 0, 0);
    for (int p = 0; p < 6; p++) begin
      sample_period = 4'(p);
      clear();
      mon_en = 1; repeat (37) step(); mon_en = 0;
      read_ctr(2, v); chk("R4 sample count", v, 37 / ((p == 0) ? 1 : p));
      read_ctr(1, v); chk("R3 off mode", v, 0);
    end

    // R5: saturation, and an independent counter alongside
    cfg(0, 1, 0, 0);
    cfg(3, 1, 1, 1);
    clear();
    for (int k = 0; k < 300; k++) begin
      mon_sig = (k < 10) ? 8'h10 : 8'h00; mon_en = 1; step();
    end
    mon_en = 0;
    read_ctr(0, v); chk("R5 saturate", v, 255);
    read_ctr(3, v); chk("R5 independent", v, 10);

    // R6: disabled cycles change nothing
    mon_sig = 8'h10; trace_evt = 1;
    repeat (20) step();
    trace_evt = 0;
    read_ctr(3, v); chk("R6 frozen counter", v, 10);
    chk("R6 no trace push", longint'(trace_level), 0);

    // R8: holding register keeps its value without a request
    mon_en = 1; repeat (5) step(); mon_en = 0;
    step();
    chk("R8 hold", longint'(ctr_rd_data), 10);
    read_ctr(3, v); chk("R8 new read", v, 15);

    // R7: clear wins over an increment in the same cycle
    mon_sig = 8'h00; mon_en = 1; clr_all = 1; step();
    mon_en = 0; clr_all = 0;
    read_ctr(0, v); chk("R7 clear priority", v, 0);
    read_ctr(3, v); chk("R7 clear all", v, 0);

    // R9 R6: timestamps since clear
    clear();
    for (int k = 0; k < 11; k++) begin
      mon_en = 1; trace_evt = (k == 2 || k == 5); trace_data = 8'(8'h40 + k); step();
    end
    mon_en = 0; trace_evt = 0;
    chk("R9 level", longint'(trace_level), 2);
    repeat (5) step();
    mon_en = 1; trace_evt = 1; trace_data = 8'h77; step();
    mon_en = 0; trace_evt = 0;
    pop_chk("R9 first record", 2, 8'h42);
    pop_chk("R9 second record", 5, 8'h45);
    pop_chk("R6 ts frozen while disabled", 11, 8'h77);
    trace_pop = 1; step(); trace_pop = 0;
    chk("R10 pop empty", longint'(trace_rd_valid), 0);
    chk("R10 level empty", longint'(trace_level), 0);

    // R11: fill past capacity
    clear();
    for (int k = 0; k < 11; k++) begin
      mon_en = 1; trace_evt = 1; trace_data = 8'(k); step();
    end
    mon_en = 0; trace_evt = 0;
    chk("R10 level full", longint'(trace_level), DEPTH);
    chk("R11 ovf", longint'(trace_ovf), 1);
    chk("R11 drops", longint'(trace_drops), 3);
    for (int k = 0; k < DEPTH; k++) pop_chk("R9 order", k, k);

    // R12: refill across the pointer wrap
    for (int k = 0; k < 3; k++) begin
      mon_en = 1; trace_evt = 1; trace_data = 8'(100 + k); step();
    end
    mon_en = 0; trace_evt = 0;
    for (int k = 0; k < 3; k++) pop_chk("R12 wrap", 11 + k, 100 + k);
    chk("R11 ovf sticky", longint'(trace_ovf), 1);
    ovf_clr = 1; step(); ovf_clr = 0;
    chk("R11 ovf clear", longint'(trace_ovf), 0);
    chk("R11 drops clear", longint'(trace_drops), 0);

    // R11: drop count saturates
    for (int k = 0; k < DEPTH + 20; k++) begin
      mon_en = 1; trace_evt = 1; trace_data = 8'(k); step();
    end
    mon_en = 0; trace_evt = 0;
    chk("R11 drops saturate", longint'(trace_drops), 15);
    chk("R11 ovf set again", longint'(trace_ovf), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule